// File: doc/BRIEF.md
# Serial Flash Protection-Clear Sequencer

This block drives a serial NOR flash through the command steps that remove its write protection while leaving the quad-enable setting untouched. A host pulses `start`. The sequencer then waits for the flash to finish any pending work and reads the upper status byte. It keeps only the quad-enable bit of that byte, sets the write-enable latch, confirms that the latch is set, and writes the two status bytes back in one command. It then waits for the flash to finish that write. The result is that every block-protect, complement and register-protect bit ends up cleared.

On the flash side the block talks to a single-lane SPI byte engine. It holds `xfer_req` with a byte on `xfer_tx` until the engine returns `xfer_ack` with the byte it shifted in on `xfer_rx`. The block drives chip select itself, holding it low for the whole of each command. It waits for `ctrl_busy` to drop before it opens a command. Each busy poll is bounded by `poll_limit`, so a flash that never becomes ready ends the run with an error instead of hanging it.

Top module: `flash_unprotect_seq`

## Requirements
- R1: A `start` pulse is accepted only while `busy` is low; `busy` rises the cycle after acceptance. A `start` pulse while `busy` is high has no effect on the commands issued or on the number of `done` pulses.
- R2: Chip select (`cs_n`, active low) never falls in a cycle that follows a clock edge at which `ctrl_busy` was high.
- R3: A status poll is one frame of two bytes: 0x05 followed by 0x00. Only the byte received during the second byte is used. The poll repeats while bit 0 (busy) of that byte is 1.
- R4: The upper status byte is read with one frame of two bytes, 0x35 then 0x00, and its value is taken from the second received byte.
- R5: Write-enable is a single-byte frame 0x06. The poll that follows it is satisfied only when bit 0 is 0 and bit 1 (write-enable latch) is 1.
- R6: The status write is one frame of three bytes: 0x01, then 0x00 as the low byte, then a high byte that is 0x02 if bit 1 of the upper byte that was read is 1, and 0x00 otherwise.
- R7: A successful run issues frames in this order: poll, upper-byte read, poll, write-enable, latch poll, status write, poll. No other frames are issued.
- R8: Within one poll phase, at most `poll_limit`+1 status reads are made. If the last of them is still not ready, the run ends with no further frames and with `error` set.
- R9: Every run ends with `done` high for exactly one cycle, with `busy` low in that cycle. `error` reflects the outcome from that cycle until the next accepted start, and it is low after a successful run.
- R10: During and right after reset, `cs_n` is high and `xfer_req`, `busy`, `done` and `error` are low.
- R11: `xfer_req` is never high while `cs_n` is high. Between two frames `cs_n` returns high for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Host request to run the sequence |
| poll_limit | input | LIMIT_W | Extra not-ready polls allowed per poll phase |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Last run timed out in a poll |
| ctrl_busy | input | 1 | Byte engine not yet idle |
| cs_n | output | 1 | Flash chip select, active low |
| xfer_req | output | 1 | Byte transfer request, held until acknowledged |
| xfer_tx | output | 8 | Byte to shift out |
| xfer_ack | input | 1 | Transfer complete, one cycle |
| xfer_rx | input | 8 | Byte shifted in during that transfer |

## Verification
The flash model returns 0xFF during the opcode byte of every read. A design that sampled the wrong byte would therefore see the flash as permanently busy, or would take every bit as set. The upper-byte values 0xFD and 0xFF check the mask. A design that copied the byte back would write protection bits, and one that dropped the quad-enable bit would write zero where 0x02 is due. Timeout runs fail during the first poll, during the latch poll and during the final poll. One run allows exactly `poll_limit`+1 reads. An off-by-one in the bound would either fail that run or issue an extra frame in the others. A late second start and a `ctrl_busy` hold check that no run restarts and that no frame opens early.

// File: rtl/flash_unprotect_seq.sv
module flash_unprotect_seq #(
  parameter int          LIMIT_W   = 16,
  parameter int          QE_BIT    = 9,
  parameter int          BUSY_BIT  = 0,
  parameter int          WEL_BIT   = 1,
  parameter logic [7:0]  OP_RD_LO  = 8'h05,
  parameter logic [7:0]  OP_RD_HI  = 8'h35,
  parameter logic [7:0]  OP_WEN    = 8'h06,
  parameter logic [7:0]  OP_WSTAT  = 8'h01,
  parameter logic [7:0]  FILL_BYTE = 8'h00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LIMIT_W-1:0] poll_limit,
  output logic               busy,
  output logic               done,
  output logic               error,
  input  logic               ctrl_busy,
  output logic               cs_n,
  output logic               xfer_req,
  output logic [7:0]         xfer_tx,
  input  logic               xfer_ack,
  input  logic [7:0]         xfer_rx
);

  localparam int         QE_HI    = QE_BIT - 8;
  localparam logic [7:0] QE_MASK  = 8'(1 << QE_HI);
  localparam logic [7:0] BSY_MASK = 8'(1 << BUSY_BIT);
  localparam logic [7:0] WEL_MASK = 8'(1 << WEL_BIT);

  typedef enum logic [1:0] {PH_IDLE, PH_ARM, PH_SHIFT, PH_GAP} phase_t;
  typedef enum logic [2:0] {
    K_POLL_PRE, K_READ_HI, K_POLL_MID, K_WREN, K_POLL_WEL, K_WRITE, K_POLL_POST
  } step_t;

  phase_t             phase;
  step_t              step;
  logic [1:0]         bidx;
  logic [1:0]         last_idx;
  logic [7:0]         rx_last;
  logic               keep_qe;
  logic [LIMIT_W-1:0] tries;
  logic               done_q, err_q;
  logic               is_poll, ready;

  assign busy     = (phase != PH_IDLE);
  assign done     = done_q;
  assign error    = err_q;
  assign cs_n     = (phase != PH_SHIFT);
  assign xfer_req = (phase == PH_SHIFT);

  assign is_poll = (step == K_POLL_PRE) || (step == K_POLL_MID) ||
                   (step == K_POLL_WEL) || (step == K_POLL_POST);
  assign ready   = ((rx_last & BSY_MASK) == 8'h00) &&
                   ((step != K_POLL_WEL) || ((rx_last & WEL_MASK) != 8'h00));

  always_comb begin
    last_idx = 2'd1;
    xfer_tx  = FILL_BYTE;
    case (step)
      K_READ_HI: xfer_tx = (bidx == 2'd0) ? OP_RD_HI : FILL_BYTE;
      K_WREN: begin
        last_idx = 2'd0;
        xfer_tx  = OP_WEN;
      end
      K_WRITE: begin
        last_idx = 2'd2;
        case (bidx)
          2'd0:    xfer_tx = OP_WSTAT;
          2'd1:    xfer_tx = 8'h00;
          default: xfer_tx = keep_qe ? QE_MASK : 8'h00;
        endcase
      end
      default:   xfer_tx = (bidx == 2'd0) ? OP_RD_LO : FILL_BYTE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      step    <= K_POLL_PRE;
      bidx    <= 2'd0;
      rx_last <= 8'h00;
      keep_qe <= 1'b0;
      tries   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_ARM;
          step  <= K_POLL_PRE;
          tries <= '0;
          err_q <= 1'b0;
        end
        PH_ARM: if (!ctrl_busy) begin
          phase <= PH_SHIFT;
          bidx  <= 2'd0;
        end
        PH_SHIFT: if (xfer_ack) begin
          rx_last <= xfer_rx;
          if (bidx == last_idx) phase <= PH_GAP;
          else                  bidx  <= bidx + 2'd1;
        end
        default: begin
          if (is_poll && !ready) begin
            if (tries == poll_limit) begin
              err_q  <= 1'b1;
              done_q <= 1'b1;
              phase  <= PH_IDLE;
            end else begin
              tries <= tries + 1'b1;
              phase <= PH_ARM;
            end
          end else begin
            tries <= '0;
            if (step == K_READ_HI) keep_qe <= ((rx_last & QE_MASK) != 8'h00);
            if (step == K_POLL_POST) begin
              done_q <= 1'b1;
              phase  <= PH_IDLE;
            end else begin
              step  <= step_t'(step + 3'd1);
              phase <= PH_ARM;
            end
          end
        end
      endcase
    end
  end

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R1
  AST_CS_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !$past(ctrl_busy)); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_ERR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> done); // R8
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n); // R11
  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx))); // R11

endmodule

// File: tb/flash_unprotect_seq_test.sv
module flash_unprotect_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] poll_limit = 16'd0;
  logic        ctrl_busy = 1'b0;
  logic        xfer_ack = 1'b0;
  logic [7:0]  xfer_rx = 8'h00;
  logic        busy, done, error, cs_n, xfer_req;
  logic [7:0]  xfer_tx;

  flash_unprotect_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .poll_limit(poll_limit),
    .busy(busy), .done(done), .error(error), .ctrl_busy(ctrl_busy),
    .cs_n(cs_n), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
    .xfer_ack(xfer_ack), .xfer_rx(xfer_rx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  int done_cnt = 0;

  logic [31:0] exp_q[$];
  int          fr_len = 0;
  logic [7:0]  fr_b [4];
  int          busy_left = 0;
  bit          wel = 0;
  bit          wel_ok_s = 1;
  int          wrbusy_s = 0;
  logic [7:0]  sr2 = 8'h00;
  bit          scen_err = 0;
  bit          exp_busy = 0;
  bit          exp_err = 0;
  bit          prev_cs = 1;
  bit          prev_busy = 0;
  bit          prev_done = 0;

  function automatic string tag_of(logic [7:0] op);
    case (op)
      8'h05:   return "R3";
      8'h35:   return "R4";
      8'h06:   return "R5";
      8'h01:   return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic summary_and_end();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic close_frame();
    logic [31:0] got, want;
    got = {8'(fr_len), fr_b[0], fr_b[1], fr_b[2]};
    vectors++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL R7 unexpected frame: got %h expected none", got);
    end else begin
      want = exp_q.pop_front();
      if (got !== want) begin
        fails++;
        $display("FAIL %s frame: got %h expected %h", tag_of(want[23:16]), got, want);
      end
    end
    if (fr_len == 1 && fr_b[0] == 8'h06) wel = wel_ok_s;
    if (fr_len == 3 && fr_b[0] == 8'h01) begin
      sr2 = fr_b[2];
      wel = 0;
      busy_left = wrbusy_s;
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_cs = 1; prev_busy = 0; prev_done = 0;
    end else begin
      logic [7:0] rx;
      cyc++;
      if (cyc > WATCHDOG) begin
        fails++;
        $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cyc, WATCHDOG);
        summary_and_end();
      end
      vectors++;
      if (xfer_req && cs_n) begin
        fails++;
        $display("FAIL R11 request outside frame: got req=1 cs_n=1 expected req=0");
      end
      if (prev_cs && !cs_n) begin
        fr_len = 0;
        for (int i = 0; i < 4; i++) fr_b[i] = 8'h00;
        vectors++;
        if (ctrl_busy) begin
          fails++;
          $display("FAIL R2 frame opened while engine busy: got ctrl_busy=1 expected 0");
        end
      end
      if (!prev_cs && cs_n) close_frame();
      if (xfer_ack) xfer_ack <= 1'b0;
      else if (xfer_req && !cs_n) begin
        rx = 8'hFF;
        if (fr_len == 1 && fr_b[0] == 8'h05) begin
          rx = {6'b101010, wel, busy_left > 0};
          if (busy_left > 0) busy_left--;
        end
        if (fr_len == 1 && fr_b[0] == 8'h35) rx = sr2;
        if (fr_len < 4) fr_b[fr_len] = xfer_tx;
        fr_len++;
        xfer_rx  <= rx;
        xfer_ack <= 1'b1;
      end
      if (start && !prev_busy) begin exp_busy = 1; exp_err = 0; end
      if (done) begin done_cnt++; exp_busy = 0; exp_err = scen_err; end
      vectors++;
      if (busy !== exp_busy) begin
        fails++;
        $display("FAIL R1 busy: got %b expected %b", busy, exp_busy);
      end
      vectors++;
      if (error !== exp_err) begin
        fails++;
        $display("FAIL R9 error: got %b expected %b", error, exp_err);
      end
      if (done && prev_done) begin
        fails++;
        $display("FAIL R9 done width: got 2+ cycles expected 1");
      end
      prev_cs = cs_n; prev_busy = busy; prev_done = done;
    end
  end

  task automatic add_frame(int len, logic [7:0] b0, logic [7:0] b1, logic [7:0] b2);
    exp_q.push_back({8'(len), b0, b1, b2});
  endtask

  task automatic add_poll(int notready, int lim, inout bit err);
    int n;
    if (notready > lim) begin n = lim + 1; err = 1; end
    else n = notready + 1;
    for (int i = 0; i < n; i++) add_frame(2, 8'h05, 8'h00, 8'h00);
  endtask

  task automatic run_case(string name, int n0, logic [7:0] s2, int wrb, bit welok,
                          int lim, int hold, bit restart);
    bit err;
    int d0, guard;
    err = 0;
    exp_q.delete();
    add_poll(n0, lim, err);
    if (!err) begin
      add_frame(2, 8'h35, 8'h00, 8'h00);
      add_poll(0, lim, err);
      add_frame(1, 8'h06, 8'h00, 8'h00);
      add_poll(welok ? 0 : lim + 1, lim, err);
    end
    if (!err) begin
      add_frame(3, 8'h01, 8'h00, s2[1] ? 8'h02 : 8'h00);
      add_poll(wrb, lim, err);
    end
    busy_left = n0; sr2 = s2; wel = 0; wel_ok_s = welok; wrbusy_s = wrb; scen_err = err;
    d0 = done_cnt;
    @(negedge clk);
    poll_limit <= 16'(lim);
    ctrl_busy  <= (hold > 0);
    start      <= 1'b1;
    @(negedge clk);
    start <= 1'b0;
    repeat (hold) @(negedge clk);
    ctrl_busy <= 1'b0;
    if (restart) begin
      repeat (6) @(negedge clk);
      start <= 1'b1;
      @(negedge clk);
      start <= 1'b0;
    end
    guard = 0;
    while (done_cnt == d0 && guard < 20000) begin @(negedge clk); guard++; end
    repeat (10) @(negedge clk);
    vectors++;
    if (done_cnt != d0 + 1) begin
      fails++;
      $display("FAIL R9 %s done pulses: got %0d expected 1", name, done_cnt - d0);
    end
    vectors++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s %s missing frames: got %0d left expected 0",
               err ? "R8" : "R7", name, exp_q.size());
    end
    if (!err) begin
      vectors++;
      if (sr2 !== (s2 & 8'h02)) begin
        fails++;
        $display("FAIL R6 %s upper status: got %h expected %h", name, sr2, s2 & 8'h02);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (cs_n !== 1'b1 || xfer_req !== 1'b0 || busy !== 1'b0 || done !== 1'b0 || error !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset outputs: got cs_n=%b req=%b busy=%b done=%b err=%b expected 1 0 0 0 0",
               cs_n, xfer_req, busy, done, error);
    end
    rst_n <= 1'b1;
    repeat (2) @(negedge clk);
    run_case("qe_kept",      0, 8'h02, 0, 1, 8, 0, 0);
    run_case("prot_cleared", 3, 8'hFD, 4, 1, 8, 5, 0);
    run_case("limit_edge",   2, 8'hFF, 2, 1, 2, 0, 0);
    run_case("timeout_pre",  3, 8'hFF, 0, 1, 2, 0, 0);
    run_case("wel_stuck",    0, 8'h42, 0, 0, 1, 0, 0);
    run_case("timeout_post", 0, 8'h02, 5, 1, 4, 0, 0);
    run_case("late_start",   1, 8'hBE, 1, 1, 3, 2, 1);
    run_case("zero_limit",   0, 8'h7F, 0, 1, 0, 0, 0);
    summary_and_end();
  end
endmodule